// File: doc/BRIEF.md
# Buffered Saturating Error Counter Bank

This block collects performance-monitoring counts for a T1/J1 receive path. Five 16-bit counters track framing bit errors, CRC6 errors, errored blocks, code violations and PRBS bit errors. An 8-bit combined counter carries two independent fields: one counts multiframes received while out of sync, the other counts changes of frame alignment. Error detection happens upstream, so each counter sees only single-cycle event pulses.

Every counter has a buffer register that software reads. A latch event copies each live count into its buffer and restarts the count. The latch event comes from one of two sources, chosen by a mode input: a one-second tick, or a software request handshake. Counters stop at their maximum value rather than wrapping. An event that arrives in the latch cycle is kept and becomes the first count of the new period. The frame bit error counter has a selectable rule for errors that coincide with a severely-errored indication.

Top module: `err_cnt_bank`

## Requirements
- R1: Each of the five 16-bit counters increases by exactly one in every cycle that its event input is high and its disable bit is low. The index order of `evt_i` and of the 16-bit slices of `buf_o` is: 0 frame bit error, 1 CRC6, 2 errored block, 3 code violation, 4 PRBS.
- R2: A 16-bit counter that has reached 65535 stays at 65535 until it is cleared.
- R3: In the combined counter, `buf_combo_o[7:2]` is the out-of-sync multiframe field and `buf_combo_o[1:0]` is the frame-alignment-change field. Each field counts its own event input, and each saturates on its own (at 63 and at 3).
- R4: While `dis_i[k]` is high, counter k does not count. `dis_i[5]` disables both fields of the combined counter.
- R5: With `ondemand_i` = 0, a high `sec_tick_i` copies every live count into its buffer at that clock edge, and every counter restarts. `req_i` has no effect in this mode.
- R6: When an enabled event arrives in the cycle of a latch, the restarted count is 1. Otherwise the restarted count is 0.
- R7: With `ondemand_i` = 1, a `req_i` pulse while `busy_o` is low latches exactly as a tick does, and sets `busy_o` for the following single cycle. A `req_i` while `busy_o` is high is ignored, and `sec_tick_i` is ignored in this mode.
- R8: When `fec_mode_i` = 0, a frame bit error is counted even when `sev_err_i` is high in the same cycle. When `fec_mode_i` = 1, that coincident error is not counted. The other counters ignore `sev_err_i`.
- R9: After reset, all buffers read 0 and `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 5 | Event pulses for the five 16-bit counters |
| mf_async_i | input | 1 | Pulse: multiframe received while out of sync |
| cofa_i | input | 1 | Pulse: change of frame alignment |
| sev_err_i | input | 1 | Severely-errored indication |
| fec_mode_i | input | 1 | Rule for frame errors that coincide with a severely-errored indication |
| dis_i | input | 6 | Per-counter disable bits (bit 5 is the combined counter) |
| ondemand_i | input | 1 | Latch source: 0 selects the one-second tick, 1 selects the request |
| sec_tick_i | input | 1 | One-second tick pulse |
| req_i | input | 1 | Software latch request |
| busy_o | output | 1 | Handshake in progress |
| buf_o | output | 80 | Buffered counts, 16 bits per counter |
| buf_combo_o | output | 8 | Buffered combined counter |

## Verification
The critical overlap is an error event that lands in the same cycle as a latch. That cycle must put the old count into the buffer and also start the new period at 1. The bench provokes this by driving random event densities while ticks and requests also arrive at random, and by holding the events high through a latch after saturation. A behavioural model advances on every clock and is compared with every buffer and with the busy flag. Any lost or double-counted event then shows up at the next latch.

// File: rtl/err_cnt_pkg.sv
package err_cnt_pkg;
  parameter int unsigned CNT_W  = 16;
  parameter int unsigned N_MAIN = 5;
  parameter int unsigned MF_W   = 6;
  parameter int unsigned COFA_W = 2;
  localparam int unsigned COMBO_W = MF_W + COFA_W;
  localparam int unsigned N_DIS   = N_MAIN + 1;
  localparam int unsigned IDX_FEC = 0;
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] buf_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q, buf_q;
  logic         hit;

  assign hit = en_i & inc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      buf_q <= '0;
    end else if (clr_i) begin
      buf_q <= cnt_q;
      cnt_q <= {{(W-1){1'b0}}, hit};
    end else if (hit && cnt_q != MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign buf_o = buf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && !clr_i) |=> cnt_q == MAX); // R2
  AST_CLEAR_KEEPS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit) |=> cnt_q == {{(W-1){1'b0}}, 1'b1}); // R6
  AST_CLEAR_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> buf_q == $past(cnt_q)); // R5
  AST_DIS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/latch_ctrl.sv
module latch_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ondemand_i,
  input  logic sec_tick_i,
  input  logic req_i,
  output logic latch_o,
  output logic busy_o
);
  logic busy_q;

  assign latch_o = ondemand_i ? (req_i & ~busy_q) : sec_tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= latch_o & ondemand_i;
  end

  assign busy_o = busy_q;

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !busy_q); // R7
  AST_BUSY_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ondemand_i && req_i && !busy_q) |=> busy_q); // R7
  AST_NO_BUSY_TICK_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ondemand_i |=> !busy_q); // R5
endmodule

// File: rtl/err_cnt_bank.sv
module err_cnt_bank
  import err_cnt_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_MAIN-1:0]         evt_i,
  input  logic                      mf_async_i,
  input  logic                      cofa_i,
  input  logic                      sev_err_i,
  input  logic                      fec_mode_i,
  input  logic [N_DIS-1:0]          dis_i,
  input  logic                      ondemand_i,
  input  logic                      sec_tick_i,
  input  logic                      req_i,
  output logic                      busy_o,
  output logic [N_MAIN*CNT_W-1:0]   buf_o,
  output logic [COMBO_W-1:0]        buf_combo_o
);
  logic              latch;
  logic [N_MAIN-1:0] inc;
  logic [CNT_W-1:0]  cnt [N_MAIN];
  logic [MF_W-1:0]   mf_cnt;
  logic [COFA_W-1:0] cofa_cnt;

  latch_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ondemand_i (ondemand_i),
    .sec_tick_i (sec_tick_i),
    .req_i      (req_i),
    .latch_o    (latch),
    .busy_o     (busy_o)
  );

  // frame bit error suppressed by a coincident severe error only in mode 1
  always_comb begin
    inc = evt_i;
    inc[IDX_FEC] = evt_i[IDX_FEC] & ~(fec_mode_i & sev_err_i);
  end

  for (genvar k = 0; k < N_MAIN; k++) begin : g_main
    sat_counter #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (~dis_i[k]),
      .inc_i  (inc[k]),
      .clr_i  (latch),
      .cnt_o  (cnt[k]),
      .buf_o  (buf_o[k*CNT_W +: CNT_W])
    );
  end

  sat_counter #(.W(MF_W)) u_mf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (~dis_i[N_MAIN]),
    .inc_i  (mf_async_i),
    .clr_i  (latch),
    .cnt_o  (mf_cnt),
    .buf_o  (buf_combo_o[COMBO_W-1:COFA_W])
  );

  sat_counter #(.W(COFA_W)) u_cofa (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (~dis_i[N_MAIN]),
    .inc_i  (cofa_i),
    .clr_i  (latch),
    .cnt_o  (cofa_cnt),
    .buf_o  (buf_combo_o[COFA_W-1:0])
  );

  AST_FEC_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fec_mode_i && sev_err_i && !latch) |=> $stable(cnt[IDX_FEC])); // R8
  AST_FEC_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fec_mode_i && evt_i[IDX_FEC] && !dis_i[IDX_FEC] && !latch
     && cnt[IDX_FEC] != '1) |=> cnt[IDX_FEC] == $past(cnt[IDX_FEC]) + 1'b1); // R8
  AST_FIELDS_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mf_async_i && !latch) |=> $stable(mf_cnt)); // R3
  AST_COFA_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cofa_cnt == '1 && !latch) |=> cofa_cnt == '1); // R3
endmodule

// File: tb/err_cnt_bank_test.sv
module err_cnt_bank_test;
  localparam int NM = 5;
  localparam int W  = 16;
  localparam int MAXC = 65535;

  logic clk = 0;
  logic rst_n = 0;
  logic [NM-1:0] evt = '0;
  logic mf = 0, cofa = 0, sev = 0, fmode = 0, od = 0, tick = 0, req = 0;
  logic [NM:0] dis = '0;
  logic busy;
  logic [NM*W-1:0] bufv;
  logic [7:0] bufc;

  always #4 clk = ~clk;

  err_cnt_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .mf_async_i(mf), .cofa_i(cofa),
    .sev_err_i(sev), .fec_mode_i(fmode), .dis_i(dis), .ondemand_i(od),
    .sec_tick_i(tick), .req_i(req), .busy_o(busy), .buf_o(bufv), .buf_combo_o(bufc)
  );

  int n_chk = 0, n_bad = 0;
  int m_cnt [NM], m_buf [NM];
  int m_mf = 0, m_cofa = 0, m_bmf = 0, m_bcofa = 0;
  bit m_busy = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural next state for the current inputs (R1 R2 R3 R4 R5 R6 R7 R8)
  task automatic model_step();
    bit lat, e;
    lat = od ? (req && !m_busy) : tick;
    for (int k = 0; k < NM; k++) begin
      e = evt[k] && !dis[k];
      if (k == 0 && fmode && sev) e = 0;
      if (lat) begin m_buf[k] = m_cnt[k]; m_cnt[k] = e ? 1 : 0; end
      else if (e && m_cnt[k] < MAXC) m_cnt[k]++;
    end
    if (lat) begin
      m_bmf = m_mf; m_bcofa = m_cofa;
      m_mf = (mf && !dis[NM]) ? 1 : 0;
      m_cofa = (cofa && !dis[NM]) ? 1 : 0;
    end else begin
      if (mf && !dis[NM] && m_mf < 63) m_mf++;
      if (cofa && !dis[NM] && m_cofa < 3) m_cofa++;
    end
    m_busy = lat && od;
  endtask

  task automatic compare_all();
    for (int k = 0; k < NM; k++)
      chk($sformatf("R1 R2 R4 R5 R6 R8 buf%0d", k), int'(bufv[k*W +: W]), m_buf[k]);
    chk("R3 mf field", int'(bufc[7:2]), m_bmf);
    chk("R3 cofa field", int'(bufc[1:0]), m_bcofa);
    chk("R7 busy", int'(busy), int'(m_busy));
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int k = 0; k < NM; k++) begin m_cnt[k] = 0; m_buf[k] = 0; end
    @(negedge clk);
    compare_all(); // R9 under reset
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare_all(); // R9 after release

    // saturation: all events high, no latch (R2 R3)
    evt = '1; mf = 1; cofa = 1;
    repeat (66000) cycle();
    // latch with events still high: buffers saturated, new count 1 (R2 R6)
    tick = 1; cycle(); tick = 0;
    evt = '0; mf = 0; cofa = 0;
    tick = 1; cycle(); tick = 0;

    // tick mode random, requests must be ignored (R5 R6 R8 R4)
    for (int i = 0; i < 4000; i++) begin
      evt = NM'($urandom); mf = 1'($urandom); cofa = 1'($urandom);
      sev = 1'($urandom); fmode = 1'(i >= 2000);
      dis = ($urandom_range(0, 7) == 0) ? (NM+1)'($urandom) : '0;
      tick = ($urandom_range(0, 40) == 0);
      req = ($urandom_range(0, 5) == 0);
      cycle();
    end
    tick = 1; req = 0; cycle(); tick = 0;

    // on-demand mode random, ticks must be ignored (R7)
    od = 1;
    for (int i = 0; i < 4000; i++) begin
      evt = NM'($urandom); mf = 1'($urandom); cofa = 1'($urandom);
      sev = 1'($urandom); fmode = 1'($urandom);
      dis = ($urandom_range(0, 7) == 0) ? (NM+1)'($urandom) : '0;
      tick = ($urandom_range(0, 3) == 0);
      req = ($urandom_range(0, 6) == 0);
      cycle();
    end
    // back-to-back requests: second is ignored while busy (R7)
    evt = '1; tick = 0;
    req = 1; cycle(); cycle(); cycle();
    req = 0; cycle(); cycle();
    finish_run();
  end
endmodule